// File: doc/BRIEF.md
# Single-Line Pixel Read Cache

This block sits between a pixel-access port and a slow backing memory. It keeps one naturally aligned line of backing memory, 4096 bytes by default, in local storage. Reads of one, two or four bytes are answered from that line. A read to any other line first invalidates the held line, pulls the whole new line in with a word burst, and then answers. Writes never allocate. Each write is forwarded to memory with byte enables and drops the held line.

A colour mode with forced alpha is selected per request. In this mode a four-byte read comes back with its top byte forced to all ones, and a four-byte write updates only the three low bytes. An invalidate input discards the held line without any memory traffic. Callers keep their accesses naturally aligned, so no access straddles two words or two lines. Multi-byte values are little-endian.

Top module: `pixel_line_cache`

## Requirements
- R1: After reset no line is held, `req_ready` is 1, and `rsp_valid`, `mem_rd_valid` and `mem_wr_valid` are 0. The first read therefore always causes a fill.
- R2: A read whose address bits above the line offset differ from the held tag, or any read while no line is held, raises `mem_rd_valid` with `mem_rd_addr` equal to the request address with its low log2(LINE_BYTES) bits cleared. It then takes exactly LINE_BYTES/4 beats of 32-bit data in address order, one per cycle with `mem_rd_dvalid` high. `req_ready` stays 0 from acceptance until the response has been given.
- R3: A read to the held line produces `rsp_valid` in the cycle right after acceptance, with no memory request.
- R4: Read data is little-endian and is taken at the request's line offset. Size code 0 returns the byte in bits 7:0. Size code 1 returns the halfword in bits 15:0. Size codes 2 and 3 return the whole word. Unused upper bits are 0.
- R5: With `req_alpha` high, a word read returns the stored word ORed with 0xFF000000. A byte or halfword read is not altered.
- R6: A write raises `mem_wr_valid` with `mem_wr_addr` equal to the request address with bits 1:0 cleared. The enables are 0001 shifted by the byte lane for a byte write, 0011 shifted by the lane for a halfword, and 1111 for a word. Each enabled byte of `mem_wr_data` carries the matching byte of the write value shifted to its lane.
- R7: A word write with `req_alpha` high uses enables 0111, so the top byte of memory is kept.
- R8: Every write drops the held line, so the next read to that line refills it.
- R9: A one-cycle pulse on `inv_i` drops the held line and starts no memory transfer. If it arrives during a fill, the fill still answers its read but leaves no line held.
- R10: `mem_rd_valid`, `mem_wr_valid` and their addresses and data hold steady until the matching ready is seen. No request is accepted while either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_i | input | 1 | Drop the held line |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = byte, 1 = halfword, 2/3 = word |
| req_alpha | input | 1 | Forced-alpha colour mode |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write value, right-aligned |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 32 | Read data |
| mem_rd_valid | output | 1 | Line burst request |
| mem_rd_ready | input | 1 | Burst request taken |
| mem_rd_addr | output | ADDR_W | Line base address |
| mem_rd_dvalid | input | 1 | Burst beat present |
| mem_rd_data | input | 32 | Burst beat data |
| mem_wr_valid | output | 1 | Single write request |
| mem_wr_ready | input | 1 | Write taken |
| mem_wr_addr | output | ADDR_W | Word address of the write |
| mem_wr_data | output | 32 | Lane-placed write data |
| mem_wr_be | output | 4 | Byte enables |

## Verification
The bench builds the block with LINE_BYTES = 64, so each fill is a 16-beat burst. A 256-byte address window then covers four lines, and random traffic switches lines, refills after writes and lands on line edges often within a short run. ADDR_W keeps its default of 32. The backing memory model inserts random gaps between burst beats and random write stalls. This exercises the beat counter and the hold-until-ready behaviour of both memory requests.

// File: rtl/pixel_line_cache.sv
module pixel_line_cache #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_alpha,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_dvalid,
  input  logic [31:0]       mem_rd_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic [3:0]        mem_wr_be
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int NWORDS = LINE_BYTES / 4;
  localparam int IDX_W  = OFF_W - 2;
  localparam int TAG_W  = ADDR_W - OFF_W;

  typedef enum logic [2:0] {S_IDLE, S_FREQ, S_FDATA, S_RESP, S_WR} state_t;

  state_t             st;
  logic               line_ok;
  logic               kill_q;
  logic [TAG_W-1:0]   tag_q;
  logic [IDX_W-1:0]   beat_q;
  logic [OFF_W-1:0]   p_off;
  logic [1:0]         p_size;
  logic               p_alpha;
  logic [31:0]        line_q [NWORDS];

  logic accept, hit;

  function automatic logic [31:0] pick(input logic [31:0] w, input logic [1:0] lane,
                                       input logic [1:0] sz, input logic alpha);
    logic [31:0] sh;
    sh = w >> {lane, 3'b000};
    case (sz)
      2'd0:    pick = {24'd0, sh[7:0]};
      2'd1:    pick = {16'd0, sh[15:0]};
      default: pick = alpha ? (w | 32'hFF00_0000) : w;
    endcase
  endfunction

  assign req_ready    = (st == S_IDLE);
  assign accept       = req_valid && req_ready;
  assign hit          = line_ok && (tag_q == req_addr[ADDR_W-1:OFF_W]);
  assign mem_rd_valid = (st == S_FREQ);
  assign mem_rd_addr  = {tag_q, {OFF_W{1'b0}}};
  assign mem_wr_valid = (st == S_WR);

  always_ff @(posedge clk) begin
    if (st == S_FDATA && mem_rd_dvalid)
      line_q[beat_q] <= mem_rd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      line_ok     <= 1'b0;
      kill_q      <= 1'b0;
      tag_q       <= '0;
      beat_q      <= '0;
      p_off       <= '0;
      p_size      <= '0;
      p_alpha     <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
      mem_wr_be   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            if (req_write) begin
              line_ok     <= 1'b0;
              mem_wr_addr <= {req_addr[ADDR_W-1:2], 2'b00};
              case (req_size)
                2'd0: begin
                  mem_wr_data <= {4{req_wdata[7:0]}};
                  mem_wr_be   <= 4'b0001 << req_addr[1:0];
                end
                2'd1: begin
                  mem_wr_data <= {2{req_wdata[15:0]}};
                  mem_wr_be   <= req_addr[1] ? 4'b1100 : 4'b0011;
                end
                default: begin
                  mem_wr_data <= req_wdata;
                  mem_wr_be   <= req_alpha ? 4'b0111 : 4'b1111;
                end
              endcase
              st <= S_WR;
            end else if (hit) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= pick(line_q[req_addr[OFF_W-1:2]], req_addr[1:0], req_size, req_alpha);
            end else begin
              line_ok <= 1'b0;
              kill_q  <= 1'b0;
              tag_q   <= req_addr[ADDR_W-1:OFF_W];
              p_off   <= req_addr[OFF_W-1:0];
              p_size  <= req_size;
              p_alpha <= req_alpha;
              st      <= S_FREQ;
            end
          end
        end
        S_FREQ: begin
          if (mem_rd_ready) begin
            beat_q <= '0;
            st     <= S_FDATA;
          end
        end
        S_FDATA: begin
          if (mem_rd_dvalid) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == IDX_W'(NWORDS - 1)) begin
              line_ok <= !kill_q;
              st      <= S_RESP;
            end
          end
        end
        S_RESP: begin
          rsp_valid <= 1'b1;
          rsp_rdata <= pick(line_q[p_off[OFF_W-1:2]], p_off[1:0], p_size, p_alpha);
          st        <= S_IDLE;
        end
        S_WR: begin
          if (mem_wr_ready) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (inv_i) begin
        line_ok <= 1'b0;
        kill_q  <= 1'b1;
      end
    end
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr)
                                      && $stable(mem_wr_data) && $stable(mem_wr_be));

  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || mem_wr_valid) |-> !req_ready);

  // R6
  wr_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> ($countones(mem_wr_be) != 0));

  // R3
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_rd_valid && !mem_wr_valid);

  // R8
  wr_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write |=> !line_ok);

endmodule

// File: tb/test_pixel_line_cache.sv
`timescale 1ns/1ps
module test_pixel_line_cache;
  localparam int AW = 32;
  localparam int LB = 64;
  localparam int NW = LB / 4;

  logic clk = 0, rst_n = 0, inv_i = 0;
  logic req_valid = 0, req_write = 0, req_alpha = 0;
  logic [1:0] req_size = 0;
  logic [AW-1:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, mem_rd_valid, mem_wr_valid;
  logic [31:0] rsp_rdata, mem_wr_data;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [3:0] mem_wr_be;
  logic mem_rd_ready = 0, mem_rd_dvalid = 0, mem_wr_ready = 0;
  logic [31:0] mem_rd_data = 0;

  pixel_line_cache #(.ADDR_W(AW), .LINE_BYTES(LB)) i_pixel_line_cache (
    .clk(clk), .rst_n(rst_n), .inv_i(inv_i),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_alpha(req_alpha), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rd_dvalid(mem_rd_dvalid), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [31:0] bmem [logic [31:0]];
  int n_fills = 0, n_writes = 0;
  logic [31:0] last_fill_addr, last_wr_addr, last_wr_data;
  logic [3:0] last_wr_be;
  int fill_beats = 0;
  logic fill_busy = 0;
  logic [31:0] fill_base;
  logic mv = 0;
  logic [31:0] mtag = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] getw(input logic [31:0] wa);
    if (bmem.exists(wa)) return bmem[wa];
    return (wa * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [31:0] a, input logic [1:0] sz, input logic al);
    logic [31:0] w;
    w = getw({a[31:2], 2'b00});
    case (sz)
      2'd0: return (w >> (8 * a[1:0])) & 32'hFF;
      2'd1: return (w >> (8 * a[1:0])) & 32'hFFFF;
      default: return al ? (w | 32'hFF00_0000) : w;
    endcase
  endfunction

  function automatic logic [3:0] exp_be(input logic [31:0] a, input logic [1:0] sz, input logic al);
    case (sz)
      2'd0: return 4'b0001 << a[1:0];
      2'd1: return 4'b0011 << a[1:0];
      default: return al ? 4'b0111 : 4'b1111;
    endcase
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mem_rd_ready) mem_rd_ready <= 0;
    mem_wr_ready <= 0;
    mem_rd_dvalid <= 0;
    if (rst_n && mem_wr_valid && ($urandom % 3 != 0)) begin
      logic [31:0] w;
      mem_wr_ready <= 1;
      w = getw(mem_wr_addr);
      for (int i = 0; i < 4; i++)
        if (mem_wr_be[i]) w[8*i +: 8] = mem_wr_data[8*i +: 8];
      bmem[mem_wr_addr] = w;
      last_wr_addr = mem_wr_addr;
      last_wr_data = mem_wr_data;
      last_wr_be = mem_wr_be;
      n_writes++;
    end
    if (fill_busy) begin
      if (fill_beats < NW && ($urandom % 4 != 0)) begin
        mem_rd_dvalid <= 1;
        mem_rd_data <= getw(fill_base + 32'(4 * fill_beats));
        fill_beats++;
      end else if (fill_beats == NW) fill_busy <= 0;
    end else if (rst_n && mem_rd_valid && !mem_rd_ready) begin
      mem_rd_ready <= 1;
      fill_base = mem_rd_addr;
      last_fill_addr = mem_rd_addr;
      fill_beats = 0;
      fill_busy <= 1;
      n_fills++;
    end
  end

  task automatic issue(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                       input logic al, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_alpha = al; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic do_read(input logic [31:0] a, input logic [1:0] sz, input logic al);
    bit miss;
    int f0, lat, busy_ready;
    logic [31:0] e;
    miss = !(mv && mtag == (a & ~32'(LB - 1)));
    f0 = n_fills;
    issue(0, a, sz, al, 0);
    lat = 0; busy_ready = 0;
    @(negedge clk);
    while (!rsp_valid && lat < 500) begin
      if (req_ready) busy_ready++;
      lat++;
      @(negedge clk);
    end
    e = exp_rd(a, sz, al);
    chk(rsp_valid == 1, "R3 response seen", 32'(rsp_valid), 1);
    if (sz == 2'd0) chk(rsp_rdata == e, "R4 byte read", rsp_rdata, e);
    else if (sz == 2'd1) chk(rsp_rdata == e, "R4 halfword read", rsp_rdata, e);
    else if (al) chk(rsp_rdata == e, "R5 forced-alpha word read", rsp_rdata, e);
    else chk(rsp_rdata == e, "R4 word read", rsp_rdata, e);
    if (miss) begin
      chk(n_fills == f0 + 1, "R2 one fill on miss", 32'(n_fills - f0), 1);
      chk(last_fill_addr == (a & ~32'(LB - 1)), "R2 fill base address", last_fill_addr, a & ~32'(LB - 1));
      chk(busy_ready == 0, "R2 req_ready low during fill", 32'(busy_ready), 0);
      mv = 1; mtag = a & ~32'(LB - 1);
    end else begin
      chk(n_fills == f0, "R3 no fill on hit", 32'(n_fills - f0), 0);
      chk(lat == 0, "R3 hit latency", 32'(lat), 0);
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [1:0] sz, input logic al, input logic [31:0] wd);
    int w0, t;
    logic [3:0] eb;
    logic [31:0] m, ed;
    w0 = n_writes;
    issue(1, a, sz, al, wd);
    t = 0;
    while (n_writes == w0 && t < 500) begin @(negedge clk); t++; end
    eb = exp_be(a, sz, al);
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{eb[i]}};
    ed = (wd << (8 * a[1:0])) & m;
    chk(n_writes == w0 + 1, "R6 one write", 32'(n_writes - w0), 1);
    chk(last_wr_addr == {a[31:2], 2'b00}, "R6 write address", last_wr_addr, {a[31:2], 2'b00});
    if (sz >= 2 && al) chk(last_wr_be == eb, "R7 alpha write enables", 32'(last_wr_be), 32'(eb));
    else chk(last_wr_be == eb, "R6 write enables", 32'(last_wr_be), 32'(eb));
    chk((last_wr_data & m) == ed, "R6 write data lanes", last_wr_data & m, ed);
    @(negedge clk);
    chk(mem_wr_valid == 0 && req_ready == 1, "R10 write released", 32'(mem_wr_valid), 0);
    mv = 0;
  endtask

  task automatic do_inv();
    int f0, w0;
    f0 = n_fills; w0 = n_writes;
    @(negedge clk); inv_i = 1;
    @(negedge clk); inv_i = 0;
    repeat (3) @(negedge clk);
    chk(n_fills == f0 && n_writes == w0 && !mem_rd_valid && !mem_wr_valid,
        "R9 invalidate makes no memory traffic", 32'(n_fills + n_writes), 32'(f0 + w0));
    mv = 0;
  endtask

  initial begin
    int f0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready after reset", 32'(req_ready), 1);
    chk(!rsp_valid && !mem_rd_valid && !mem_wr_valid, "R1 outputs idle after reset",
        32'({rsp_valid, mem_rd_valid, mem_wr_valid}), 0);
    f0 = n_fills;
    do_read(32'h1000, 2, 0);
    chk(n_fills == f0 + 1, "R1 first read misses", 32'(n_fills - f0), 1);
    for (int i = 0; i < 4; i++) do_read(32'h1004 + 32'(i), 0, 0);
    do_read(32'h1008, 1, 0);
    do_read(32'h100A, 1, 1);
    do_read(32'h1000 + 32'(LB - 4), 2, 1);
    do_read(32'h1000 + 32'(LB), 2, 0);
    do_read(32'h1000 + 32'(LB - 1), 0, 0);
    do_write(32'h1010, 2, 1, 32'h1122_3344);
    do_read(32'h1010, 2, 0);
    do_write(32'h1013, 0, 0, 32'h0000_00AB);
    do_write(32'h1016, 1, 0, 32'h0000_BEEF);
    do_read(32'h1014, 2, 0);
    do_read(32'h1010, 2, 1);
    do_inv();
    do_read(32'h1010, 2, 0);
    do_read(32'h1000, 0, 0);
    // R9: invalidate in the middle of a fill
    fork
      do_read(32'h1000 + 32'(2 * LB), 2, 0);
      begin repeat (6) @(negedge clk); inv_i = 1; @(negedge clk); inv_i = 0; end
    join
    mv = 0;
    do_read(32'h1000 + 32'(2 * LB) + 4, 2, 0);
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [1:0] sz;
      logic [31:0] a;
      logic al;
      op = $urandom % 10;
      sz = 2'($urandom % 3);
      a = (32'h1000 + ($urandom % 256)) & ~((32'd1 << sz) - 1);
      al = ($urandom % 4 == 0);
      if (op < 6) do_read(a, sz, al);
      else if (op < 9) do_write(a, sz, al, $urandom);
      else do_inv();
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual cycles=%0d expected below 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule